// File: doc/BRIEF.md
# Variable Range Memory Type Matcher

This block holds eight programmable physical-address ranges, each described by a base register and a mask register. Each range carries an 8-bit memory type. A 40-bit physical address is looked up against all ranges at once. The block returns the memory type of the matching range. When nothing matches, it returns a programmable fallback type. When several ranges overlap, a fixed resolution rule decides the result.

Software programs the block through one 64-bit write port. The write selects a register kind (base, mask, fallback type, or an unused code) and a range index. Every write is screened for bits that must be zero. A screened-out write leaves the register untouched and produces a one-cycle fault pulse. The lookup port accepts the page-frame part of the address, bits 39:12, because the low 12 bits never take part in a compare. It answers exactly one clock later.

Top module: `mtr_top`

## Requirements
- R1: After reset every register is zero. No range is valid, the fallback type is 0, a lookup returns type 0, and `wr_fault_o` is low.
- R2: `wr_kind_i` selects the target. 0 is a base register: the address is in bits 39:12 and the type in bits 7:0. 1 is a mask register: the mask is in bits 39:12 and the valid flag in bit 11. 2 is the fallback type, in bits 7:0. `wr_pair_i` picks the range for kinds 0 and 1. A legal write updates the register at that clock edge.
- R3: A write with any of bits 63:40 set is rejected. The target keeps its previous value.
- R4: A base write with any of bits 11:8 set is rejected, and so is a mask write with any of bits 10:0 set. A fallback write with any of bits 63:8 set is rejected. The target keeps its previous value in each case.
- R5: A range matches when its valid flag is set and `(pfn & mask)` equals `(base & mask)` over all 28 bits 39:12, including the top bits 39:36.
- R6: When no valid range matches, the result is the fallback type.
- R7: If any matching range has type 0 (uncacheable), the result is 0.
- R8: If only types 4 (write-through) and 6 (write-back) match, and both are present, the result is 4.
- R9: If all matching ranges share one type, the result is that type. Any other mix of types gives 0.
- R10: `lk_valid_o` is high exactly one clock after `lk_valid_i`. `lk_type_o` then holds the result for the registers as they were at the request edge.
- R11: `wr_fault_o` pulses high for one clock after each rejected write, and only then. A write with `wr_kind_i` = 3 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Target kind: 0 base, 1 mask, 2 fallback type, 3 invalid |
| wr_pair_i | input | 3 | Range index for base and mask writes |
| wr_data_i | input | 64 | Write data |
| wr_fault_o | output | 1 | One-cycle pulse after a rejected write |
| lk_valid_i | input | 1 | Lookup request |
| lk_pfn_i | input | 28 | Physical address bits 39:12 to classify |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_type_o | output | 8 | Resolved memory type |

## Verification
The bench targets overlap resolution because it is easy to get wrong:
- A design that took the lowest-indexed match would return write-back where uncacheable or write-through is required.
- A design that treated write-through plus write-combining like write-through plus write-back would return 4 instead of 0.

It probes the top address bits 39:36 because a compare truncated to 36 bits would report a false match.

It sends rejected writes of every kind and then looks up the affected range. A design that wrote the register despite the fault would return a changed type or a changed match.

Randomised masks of varying alignment stress the masked compare against the bench's own model.

// File: rtl/mtr_pkg.sv
// Package: shared encodings for the variable range memory type matcher.
// Assumes: memory types are 8-bit codes; only 0, 4 and 6 have special
// meaning during overlap resolution.
package mtr_pkg;

    typedef enum logic [1:0] {
        KIND_BASE = 2'd0,
        KIND_MASK = 2'd1,
        KIND_DFLT = 2'd2,
        KIND_NONE = 2'd3
    } wr_kind_e;

    localparam logic [7:0] MT_UC = 8'd0;
    localparam logic [7:0] MT_WT = 8'd4;
    localparam logic [7:0] MT_WB = 8'd6;

endpackage

// File: rtl/mtr_wr_check.sv
// Module: mtr_wr_check
// Screens a register write for bits that must be zero, given the target kind.
// Assumes: PG_LSB > TYPE_W, so a gap of reserved bits sits between the type
// field and the page field of a base register; the valid flag is at PG_LSB-1.
module mtr_wr_check
    import mtr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PA_W   = 40,
    parameter int PG_LSB = 12,
    parameter int TYPE_W = 8
) (
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              legal_o
);
    logic upper_clear;
    logic base_gap_clear;
    logic mask_low_clear;
    logic dflt_clear;

    // Purpose: compute each reserved-field test independently.
    always_comb begin
        upper_clear    = (data_i[DATA_W-1:PA_W] == '0);
        base_gap_clear = (data_i[PG_LSB-1:TYPE_W] == '0);
        mask_low_clear = (data_i[PG_LSB-2:0] == '0);
        dflt_clear     = (data_i[DATA_W-1:TYPE_W] == '0);
    end

    // Purpose: pick the test set that applies to the selected kind.
    always_comb begin
        unique case (wr_kind_e'(kind_i))
            KIND_BASE: legal_o = upper_clear && base_gap_clear;
            KIND_MASK: legal_o = upper_clear && mask_low_clear;
            KIND_DFLT: legal_o = dflt_clear;
            default:   legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mtr_pair.sv
// Module: mtr_pair
// Holds one base/mask range and reports whether a page-frame number hits it.
// Assumes: write enables are already qualified by the legality check; the
// compare always spans the full page field.
module mtr_pair #(
    parameter int PFN_W  = 28,
    parameter int TYPE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              base_we_i,
    input  logic              mask_we_i,
    input  logic [PFN_W-1:0]  wr_pfn_i,
    input  logic [TYPE_W-1:0] wr_type_i,
    input  logic              wr_valid_i,
    input  logic [PFN_W-1:0]  lk_pfn_i,
    output logic              hit_o,
    output logic [TYPE_W-1:0] type_o
);
    logic [PFN_W-1:0]  base_q;
    logic [PFN_W-1:0]  mask_q;
    logic [TYPE_W-1:0] type_q;
    logic              valid_q;

    // Purpose: store the base half (page field and type).
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            base_q <= '0;
            type_q <= '0;
        end else if (base_we_i) begin
            base_q <= wr_pfn_i;
            type_q <= wr_type_i;
        end
    end

    // Purpose: store the mask half (page mask and valid flag).
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q  <= '0;
            valid_q <= 1'b0;
        end else if (mask_we_i) begin
            mask_q  <= wr_pfn_i;
            valid_q <= wr_valid_i;
        end
    end

    // Purpose: masked compare of the lookup frame against the base.
    always_comb begin
        hit_o  = valid_q && ((lk_pfn_i & mask_q) == (base_q & mask_q));
        type_o = type_q;
    end

endmodule

// File: rtl/mtr_resolve.sv
// Module: mtr_resolve
// Merges the per-range hits into one memory type.
// Rules: no hit -> fallback; any UC -> UC; one shared type -> that type;
// only WT and WB -> WT; anything else -> UC.
// Assumes: types arrive flattened, range i in bits [i*TYPE_W +: TYPE_W].
module mtr_resolve
    import mtr_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    parameter int TYPE_W    = 8
) (
    input  logic [NUM_PAIRS-1:0]        hit_i,
    input  logic [NUM_PAIRS*TYPE_W-1:0] types_i,
    input  logic [TYPE_W-1:0]           dflt_i,
    output logic [TYPE_W-1:0]           type_o
);
    logic              any_hit;
    logic              any_uc;
    logic              all_same;
    logic              only_wt_wb;
    logic [TYPE_W-1:0] first_type;

    // Purpose: scan the hit ranges and collect the resolution flags.
    always_comb begin
        any_hit    = 1'b0;
        any_uc     = 1'b0;
        all_same   = 1'b1;
        only_wt_wb = 1'b1;
        first_type = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (hit_i[i]) begin
                if (types_i[i*TYPE_W +: TYPE_W] == TYPE_W'(MT_UC)) begin
                    any_uc = 1'b1;
                end
                if ((types_i[i*TYPE_W +: TYPE_W] != TYPE_W'(MT_WT)) &&
                    (types_i[i*TYPE_W +: TYPE_W] != TYPE_W'(MT_WB))) begin
                    only_wt_wb = 1'b0;
                end
                if (!any_hit) begin
                    first_type = types_i[i*TYPE_W +: TYPE_W];
                end else if (types_i[i*TYPE_W +: TYPE_W] != first_type) begin
                    all_same = 1'b0;
                end
                any_hit = 1'b1;
            end
        end
    end

    // Purpose: apply the precedence order to the flags.
    always_comb begin
        if (!any_hit) begin
            type_o = dflt_i;
        end else if (any_uc) begin
            type_o = TYPE_W'(MT_UC);
        end else if (all_same) begin
            type_o = first_type;
        end else if (only_wt_wb) begin
            type_o = TYPE_W'(MT_WT);
        end else begin
            type_o = TYPE_W'(MT_UC);
        end
    end

endmodule

// File: rtl/mtr_top.sv
// Module: mtr_top
// Variable range memory type matcher: NUM_PAIRS base/mask ranges, a fallback
// type register, a screened write port and a one-cycle lookup.
// Assumes: lookups see register contents as of the request edge; a write
// and a lookup in the same cycle give the pre-write answer.
module mtr_top
    import mtr_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    parameter int DATA_W    = 64,
    parameter int PA_W      = 40,
    parameter int PG_LSB    = 12,
    parameter int TYPE_W    = 8,
    localparam int PFN_W    = PA_W - PG_LSB,
    localparam int IDX_W    = $clog2(NUM_PAIRS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_kind_i,
    input  logic [IDX_W-1:0]  wr_pair_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_fault_o,
    input  logic              lk_valid_i,
    input  logic [PFN_W-1:0]  lk_pfn_i,
    output logic              lk_valid_o,
    output logic [TYPE_W-1:0] lk_type_o
);
    logic                        wr_legal;
    logic                        wr_ok;
    logic [NUM_PAIRS-1:0]        hit_vec;
    logic [NUM_PAIRS*TYPE_W-1:0] type_flat;
    logic [TYPE_W-1:0]           dflt_q;
    logic [TYPE_W-1:0]           resolved;
    logic                        fault_q;
    logic                        lk_valid_q;
    logic [TYPE_W-1:0]           lk_type_q;

    mtr_wr_check #(
        .DATA_W (DATA_W),
        .PA_W   (PA_W),
        .PG_LSB (PG_LSB),
        .TYPE_W (TYPE_W)
    ) wr_check_i (
        .kind_i  (wr_kind_i),
        .data_i  (wr_data_i),
        .legal_o (wr_legal)
    );

    // Purpose: a write takes effect only when strobed and legal.
    always_comb wr_ok = wr_en_i && wr_legal;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic base_we;
        logic mask_we;

        // Purpose: decode the range index and kind into this range's enables.
        always_comb begin
            base_we = wr_ok && (wr_pair_i == IDX_W'(g)) &&
                      (wr_kind_e'(wr_kind_i) == KIND_BASE);
            mask_we = wr_ok && (wr_pair_i == IDX_W'(g)) &&
                      (wr_kind_e'(wr_kind_i) == KIND_MASK);
        end

        mtr_pair #(
            .PFN_W  (PFN_W),
            .TYPE_W (TYPE_W)
        ) pair_i (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .base_we_i  (base_we),
            .mask_we_i  (mask_we),
            .wr_pfn_i   (wr_data_i[PA_W-1:PG_LSB]),
            .wr_type_i  (wr_data_i[TYPE_W-1:0]),
            .wr_valid_i (wr_data_i[PG_LSB-1]),
            .lk_pfn_i   (lk_pfn_i),
            .hit_o      (hit_vec[g]),
            .type_o     (type_flat[g*TYPE_W +: TYPE_W])
        );
    end

    // Purpose: fallback type register, returned when no range hits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dflt_q <= '0;
        end else if (wr_ok && (wr_kind_e'(wr_kind_i) == KIND_DFLT)) begin
            dflt_q <= wr_data_i[TYPE_W-1:0];
        end
    end

    mtr_resolve #(
        .NUM_PAIRS (NUM_PAIRS),
        .TYPE_W    (TYPE_W)
    ) resolve_i (
        .hit_i   (hit_vec),
        .types_i (type_flat),
        .dflt_i  (dflt_q),
        .type_o  (resolved)
    );

    // Purpose: one-cycle fault pulse after a rejected write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= wr_en_i && !wr_legal;
        end
    end

    // Purpose: register the lookup answer with one clock of latency.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lk_valid_q <= 1'b0;
            lk_type_q  <= '0;
        end else begin
            lk_valid_q <= lk_valid_i;
            if (lk_valid_i) begin
                lk_type_q <= resolved;
            end
        end
    end

    assign wr_fault_o = fault_q;
    assign lk_valid_o = lk_valid_q;
    assign lk_type_o  = lk_type_q;

endmodule

// File: rtl/mtr_top_chk.sv
// Module: mtr_top_chk
// Temporal checks for mtr_top, attached by bind. Watches ports plus the
// per-range hits, per-range types and fallback register.
module mtr_top_chk #(
    parameter int NUM_PAIRS = 8,
    parameter int DATA_W    = 64,
    parameter int TYPE_W    = 8
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        wr_en_i,
    input logic [1:0]                  wr_kind_i,
    input logic [DATA_W-1:0]           wr_data_i,
    input logic                        wr_fault_o,
    input logic                        lk_valid_i,
    input logic                        lk_valid_o,
    input logic [TYPE_W-1:0]           lk_type_o,
    input logic [NUM_PAIRS-1:0]        hit_vec,
    input logic [NUM_PAIRS*TYPE_W-1:0] type_flat,
    input logic [TYPE_W-1:0]           dflt_q
);
    logic any_uc_hit;
    logic any_wt_hit;
    logic any_wb_hit;
    logic any_other_hit;

    // Purpose: classify the hitting ranges by type for the overlap checks.
    always_comb begin
        any_uc_hit    = 1'b0;
        any_wt_hit    = 1'b0;
        any_wb_hit    = 1'b0;
        any_other_hit = 1'b0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (hit_vec[i]) begin
                if (type_flat[i*TYPE_W +: TYPE_W] == TYPE_W'(0))      any_uc_hit = 1'b1;
                else if (type_flat[i*TYPE_W +: TYPE_W] == TYPE_W'(4)) any_wt_hit = 1'b1;
                else if (type_flat[i*TYPE_W +: TYPE_W] == TYPE_W'(6)) any_wb_hit = 1'b1;
                else                                                  any_other_hit = 1'b1;
            end
        end
    end

    a_r10_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_i |=> lk_valid_o);

    a_r10_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_valid_i |=> !lk_valid_o);

    a_r3_upper_bits_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_data_i[DATA_W-1:40] != '0)) |=> wr_fault_o);

    a_r11_kind3_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_kind_i == 2'd3)) |=> wr_fault_o);

    a_r11_fault_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> !wr_fault_o);

    a_r6_fallback_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_i && (hit_vec == '0)) |=> (lk_type_o == $past(dflt_q)));

    a_r7_uc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_i && any_uc_hit) |=> (lk_type_o == '0));

    a_r8_wt_over_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_i && any_wt_hit && any_wb_hit && !any_uc_hit && !any_other_hit)
        |=> (lk_type_o == TYPE_W'(4)));

endmodule

bind mtr_top mtr_top_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .DATA_W    (DATA_W),
    .TYPE_W    (TYPE_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_kind_i  (wr_kind_i),
    .wr_data_i  (wr_data_i),
    .wr_fault_o (wr_fault_o),
    .lk_valid_i (lk_valid_i),
    .lk_valid_o (lk_valid_o),
    .lk_type_o  (lk_type_o),
    .hit_vec    (hit_vec),
    .type_flat  (type_flat),
    .dflt_q     (dflt_q)
);

// File: tb/mtr_top_tb_top.sv
// Bench for mtr_top: directed corner cases, then seeded random traffic,
// all compared against a shadow model built from the requirements.
module mtr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [2:0]  wr_pair = '0;
    logic [63:0] wr_data = '0;
    logic        wr_fault;
    logic        lk_valid = 1'b0;
    logic [27:0] lk_pfn = '0;
    logic        lk_valid_q;
    logic [7:0]  lk_type;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] sh_base [8];
    logic [63:0] sh_mask [8];
    logic [7:0]  sh_dflt;

    always #2 clk = ~clk;

    mtr_top dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_kind_i  (wr_kind),
        .wr_pair_i  (wr_pair),
        .wr_data_i  (wr_data),
        .wr_fault_o (wr_fault),
        .lk_valid_i (lk_valid),
        .lk_pfn_i   (lk_pfn),
        .lk_valid_o (lk_valid_q),
        .lk_type_o  (lk_type)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Legality from R3, R4, R11.
    function automatic bit legal(input logic [1:0] kind, input logic [63:0] d);
        case (kind)
            2'd0: return (d[63:40] == 0) && (d[11:8] == 0);
            2'd1: return (d[63:40] == 0) && (d[10:0] == 0);
            2'd2: return (d[63:8] == 0);
            default: return 1'b0;
        endcase
    endfunction

    // Expected type from R5 through R9.
    function automatic logic [7:0] exp_type(input logic [27:0] pfn);
        int nh = 0, nuc = 0, nwtwb = 0;
        bit same = 1'b1;
        logic [7:0] first = '0;
        for (int i = 0; i < 8; i++) begin
            logic [27:0] m = sh_mask[i][39:12];
            if (sh_mask[i][11] && ((pfn & m) == (sh_base[i][39:12] & m))) begin
                logic [7:0] t = sh_base[i][7:0];
                if (nh == 0) first = t;
                else if (t != first) same = 1'b0;
                if (t == 8'd0) nuc++;
                if (t == 8'd4 || t == 8'd6) nwtwb++;
                nh++;
            end
        end
        if (nh == 0) return sh_dflt;
        if (nuc > 0) return 8'd0;
        if (same) return first;
        if (nwtwb == nh) return 8'd4;
        return 8'd0;
    endfunction

    task automatic do_write(input logic [1:0] kind, input logic [2:0] pair,
                            input logic [63:0] d, input string req);
        bit ok = legal(kind, d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_pair = pair; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(wr_fault == !ok, req, {63'd0, wr_fault}, {63'd0, !ok});
        if (ok) begin
            if (kind == 2'd0) sh_base[pair] = d;
            else if (kind == 2'd1) sh_mask[pair] = d;
            else sh_dflt = d[7:0];
        end
    endtask

    task automatic do_lookup(input logic [27:0] pfn, input string req);
        logic [7:0] e = exp_type(pfn);
        @(negedge clk);
        lk_valid = 1'b1; lk_pfn = pfn;
        @(negedge clk);
        lk_valid = 1'b0;
        check(lk_valid_q == 1'b1, {req, " R10 valid"}, {63'd0, lk_valid_q}, 64'd1);
        check(lk_type == e, req, {56'd0, lk_type}, {56'd0, e});
    endtask

    function automatic logic [63:0] mk_base(input logic [27:0] pfn, input logic [7:0] t);
        return {24'd0, pfn, 4'd0, t};
    endfunction

    function automatic logic [63:0] mk_mask(input logic [27:0] m, input bit v);
        return {24'd0, m, v, 11'd0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hang expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7411));
        for (int i = 0; i < 8; i++) begin sh_base[i] = '0; sh_mask[i] = '0; end
        sh_dflt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(wr_fault == 1'b0, "R1 fault low", {63'd0, wr_fault}, 64'd0);
        check(lk_valid_q == 1'b0, "R1 valid low", {63'd0, lk_valid_q}, 64'd0);
        do_lookup(28'h0000000, "R1 reset lookup");
        @(negedge clk);
        check(lk_valid_q == 1'b0, "R10 valid drops", {63'd0, lk_valid_q}, 64'd0);

        // R6: fallback type
        do_write(2'd2, 3'd0, 64'h6, "R6 fallback write");
        do_lookup(28'h1234567, "R6 fallback on miss");

        // R2, R5: one 4K range
        do_write(2'd0, 3'd0, mk_base(28'h0100000, 8'd6), "R2 base write");
        do_write(2'd1, 3'd0, mk_mask(28'hFFFFFFF, 1'b0), "R2 mask write invalid");
        do_lookup(28'h0100000, "R5 invalid range ignored");
        do_write(2'd1, 3'd0, mk_mask(28'hFFFFFFF, 1'b1), "R2 mask write valid");
        do_lookup(28'h0100000, "R5 exact hit");
        do_lookup(28'h0100001, "R5 adjacent page misses");
        do_lookup(28'h8100000, "R5 bit 39 differs");
        do_write(2'd0, 3'd1, mk_base(28'h8200000, 8'd5), "R2 high base");
        do_write(2'd1, 3'd1, mk_mask(28'hFF00000, 1'b1), "R2 high mask");
        do_lookup(28'h82ABCDE, "R5 high range hit");
        do_lookup(28'h02ABCDE, "R5 top bit needed");

        // R3: upper bits rejected, register unchanged
        do_write(2'd0, 3'd0, mk_base(28'h0100000, 8'd1) | 64'h1 << 40, "R3 bit40 base");
        do_write(2'd1, 3'd0, mk_mask(28'h0, 1'b1) | 64'h1 << 63, "R3 bit63 mask");
        do_lookup(28'h0100000, "R3 range unchanged");

        // R4: middle reserved bits rejected
        do_write(2'd0, 3'd0, mk_base(28'h0100000, 8'd1) | 64'h100, "R4 base bit8");
        do_write(2'd1, 3'd0, mk_mask(28'h0, 1'b1) | 64'h1, "R4 mask bit0");
        do_write(2'd2, 3'd0, 64'h106, "R4 fallback bit8");
        do_lookup(28'h0100000, "R4 range unchanged");
        do_lookup(28'h0300000, "R4 fallback unchanged");

        // R11: kind 3 always rejected
        do_write(2'd3, 3'd0, 64'h0, "R11 kind3");

        // R7, R8, R9: overlap on frame 0x0100000 using range 2
        do_write(2'd1, 3'd2, mk_mask(28'hFFFF000, 1'b1), "R2 overlap mask");
        do_write(2'd0, 3'd2, mk_base(28'h0100000, 8'd0), "R2 overlap UC");
        do_lookup(28'h0100000, "R7 UC wins");
        do_write(2'd0, 3'd2, mk_base(28'h0100000, 8'd4), "R2 overlap WT");
        do_lookup(28'h0100000, "R8 WT over WB");
        do_lookup(28'h0100ABC, "R9 single WT range");
        do_write(2'd0, 3'd2, mk_base(28'h0100000, 8'd1), "R2 overlap WC");
        do_lookup(28'h0100000, "R9 mixed gives UC");
        do_write(2'd0, 3'd2, mk_base(28'h0100000, 8'd6), "R2 overlap WB");
        do_lookup(28'h0100000, "R9 same type kept");

        // Random traffic
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 9);
            logic [2:0] p = 3'($urandom_range(0, 7));
            if (op < 3) begin
                logic [7:0] tsel [5] = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
                logic [63:0] d = mk_base(28'($urandom()), tsel[$urandom_range(0, 4)]);
                if ($urandom_range(0, 7) == 0) d[$urandom_range(8, 63)] = 1'b1;
                do_write(2'd0, p, d, "R2 R3 R4 random base");
            end else if (op < 5) begin
                int k = $urandom_range(0, 24);
                logic [63:0] d = mk_mask(28'hFFFFFFF << k, $urandom_range(0, 3) != 0);
                if ($urandom_range(0, 7) == 0) d[$urandom_range(0, 63)] = 1'b1;
                do_write(2'd1, p, d, "R2 R3 R4 random mask");
            end else if (op == 5) begin
                logic [63:0] d = {56'd0, 8'($urandom())};
                if ($urandom_range(0, 3) == 0) d[$urandom_range(8, 63)] = 1'b1;
                do_write(2'($urandom_range(2, 3)), p, d, "R6 R11 random fallback");
            end else begin
                logic [27:0] a = sh_base[p][39:12] ^ (28'($urandom()) >> $urandom_range(0, 28));
                do_lookup(a, "R5 R9 random lookup");
            end
        end

        finish_run();
    end

endmodule